// File: doc/BRIEF.md
# Switchable-Depth Receive Byte Queue

This block holds the bytes a serial port has received until software reads them through the data register. Bytes arrive on a write port, either from the line receiver or looped back from the transmit side. A read strobe removes the oldest byte. The head byte is always visible on the read data output.

The queue runs in one of two modes, chosen by bit 0 of the FIFO control value that software writes. In character mode the queue holds a single byte. In queue mode it holds up to sixteen bytes. When the mode changes, the stored bytes are discarded. A separate flag in the same control write also discards them on demand. The stored control value is driven out so that neighbouring register logic can report the mode.

The block drives out the fill level, a non-empty flag, a space flag and a one-cycle overrun pulse. The overrun pulse marks a byte that was dropped because the queue was full.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset the level is 0, the stored control value is 0x00, not_empty is 0, has_space is 1 and the queue is in character mode (capacity 1).
- R2: In character mode (stored control bit 0 = 0) the capacity is one byte. A push while one byte is held and no byte is popped is dropped, and the held byte is kept.
- R3: In queue mode (stored control bit 0 = 1) the capacity is FIFO_DEPTH (16) bytes. Bytes leave in arrival order, and pointers wrap round the current capacity.
- R4: A control write whose bit 0 differs from the stored bit 0 empties the queue and sets the capacity to 16 when the new bit is 1, or to 1 when it is 0.
- R5: A control write with bit 0 = 0 stores 0x00. All other bits of that write are ignored.
- R6: A control write with bit 0 = 1 stores the written value masked with 0xC9, keeping bits 0, 3, 6 and 7. If bit 1 of that write is 1, the queue is emptied.
- R7: While the queue is empty, rd_data reads 0xFF. A read strobe then changes neither the level nor which byte appears next.
- R8: A push and an effective pop in the same cycle leave the level unchanged. This holds even when the queue is full, in which case the pushed byte is accepted. A push and a pop on an empty queue store the byte, and the level becomes 1.
- R9: In a cycle where a control write empties the queue, a push or pop in that cycle has no effect and raises no overrun.
- R10: not_empty is 1 exactly when the level is non-zero, and has_space is 1 exactly when the level is below the current capacity. rd_data shows the oldest byte in the cycle after that byte is stored or reaches the head.
- R11: overrun is high for exactly the one cycle after a dropped push, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Push a received byte |
| wr_data | input | DATA_W | Byte to push |
| rd_en | input | 1 | Data register read strobe (pop) |
| rd_data | output | DATA_W | Head byte, or all ones when empty |
| fcr_we | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write value |
| fcr_q | output | 8 | Stored FIFO control value |
| level | output | CNT_W | Number of bytes held |
| not_empty | output | 1 | Queue holds at least one byte |
| has_space | output | 1 | Queue level is below its capacity |
| overrun | output | 1 | One-cycle pulse after a dropped push |

## Verification
Two pairs of actions can fall in the same cycle: a push with a pop, and a control write with a push or pop. The bench provokes both on purpose:
- a push with a pop on a full queue, on an empty queue and in character mode;
- a push with a mode-toggling or receive-reset control write.

Random traffic with occasional control writes adds further coincidences. A behavioural queue model compares level, flags, head byte, stored control value and the overrun pulse after every clock edge.

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              fcr_we,
  input  logic [7:0]        fcr_wdata,
  output logic [7:0]        fcr_q,
  output logic [CNT_W-1:0]  level,
  output logic              not_empty,
  output logic              has_space,
  output logic              overrun
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam logic [7:0] KEEP_MASK = 8'hC9;

  logic [DATA_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic              q_mode;
  logic [CNT_W-1:0]  cap;
  logic              mode_flip, rx_reset, flush;
  logic              pop_ok, push_ok, push_drop;

  assign q_mode    = fcr_q[0];
  assign cap       = q_mode ? CNT_W'(FIFO_DEPTH) : CNT_W'(1);
  assign mode_flip = fcr_we && (fcr_wdata[0] != q_mode);
  assign rx_reset  = fcr_we && fcr_wdata[0] && fcr_wdata[1];
  assign flush     = mode_flip || rx_reset;

  assign pop_ok    = rd_en && (level != '0) && !flush;
  assign push_ok   = wr_en && !flush && ((level < cap) || pop_ok);
  assign push_drop = wr_en && !flush && !push_ok;

  assign not_empty = (level != '0);
  assign has_space = (level < cap);
  assign rd_data   = not_empty ? mem[rptr] : {DATA_W{1'b1}};

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p, input logic m);
    if (!m || p == PTR_W'(FIFO_DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcr_q <= 8'h00;
    end else if (fcr_we) begin
      fcr_q <= fcr_wdata[0] ? (fcr_wdata & KEEP_MASK) : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= push_drop;
      if (flush) begin
        wptr  <= '0;
        rptr  <= '0;
        level <= '0;
      end else begin
        if (push_ok) wptr <= bump(wptr, q_mode);
        if (pop_ok)  rptr <= bump(rptr, q_mode);
        level <= level + CNT_W'(push_ok) - CNT_W'(pop_ok);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wr_data;
  end
endmodule

// File: rtl/rx_byte_queue_chk.sv
module rx_byte_queue_chk #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic             fcr_we,
  input logic [7:0]       fcr_wdata,
  input logic [7:0]       fcr_q,
  input logic [CNT_W-1:0] level,
  input logic             overrun
);
  logic [CNT_W-1:0] cap;
  assign cap = fcr_q[0] ? CNT_W'(FIFO_DEPTH) : CNT_W'(1);

  assert_level_in_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= cap);

  assert_char_mode_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fcr_q[0] |-> level <= CNT_W'(1));

  assert_toggle_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_we && fcr_wdata[0] != fcr_q[0]) |=> level == '0);

  assert_disable_zeroes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_we && !fcr_wdata[0]) |=> fcr_q == 8'h00);

  assert_masked_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_q & 8'h36) == 8'h00);

  assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !fcr_we && level == '0) |=> level == '0);

  assert_push_pop_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !fcr_we && level != '0) |=> $stable(level));

  assert_flush_no_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_we && fcr_wdata[0] != fcr_q[0]) |=> !overrun);

  assert_overrun_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(wr_en) && $past(level) == $past(cap));

  assert_overrun_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !wr_en) |=> !overrun);
endmodule

bind rx_byte_queue rx_byte_queue_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .fcr_we(fcr_we),
  .fcr_wdata(fcr_wdata), .fcr_q(fcr_q), .level(level), .overrun(overrun)
);

// File: tb/test_rx_byte_queue.sv
module test_rx_byte_queue;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int CW     = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, fcr_we = 0;
  logic [7:0] wr_data = 0, fcr_wdata = 0;
  logic [7:0] rd_data, fcr_q;
  logic [CW-1:0] level;
  logic not_empty, has_space, overrun;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  logic [7:0] q[$];
  logic [7:0] fcr_m = 8'h00;
  bit ov_m = 0;

  always #(PERIOD/2) clk = ~clk;

  rx_byte_queue #(.FIFO_DEPTH(DEPTH)) i_rx_byte_queue (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata), .fcr_q(fcr_q),
    .level(level), .not_empty(not_empty), .has_space(has_space), .overrun(overrun)
  );

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int cap = fcr_m[0] ? DEPTH : 1;
    chk("level", int'(level), q.size());
    chk("not_empty", int'(not_empty), int'(q.size() != 0));
    chk("has_space", int'(has_space), int'(q.size() < cap));
    chk("rd_data", int'(rd_data), q.size() != 0 ? int'(q[0]) : 'hFF);
    chk("fcr_q", int'(fcr_q), int'(fcr_m));
    chk("overrun", int'(overrun), int'(ov_m));
  endtask

  task automatic step(bit p, logic [7:0] pd, bit r, bit fw, logic [7:0] fd);
    int cap;
    bit fl, popped;
    wr_en = p; wr_data = pd; rd_en = r; fcr_we = fw; fcr_wdata = fd;
    @(posedge clk);
    #1;
    cap = fcr_m[0] ? DEPTH : 1;
    fl = fw && ((fd[0] != fcr_m[0]) || (fd[0] && fd[1]));
    ov_m = 0;
    if (fw) fcr_m = fd[0] ? (fd & 8'hC9) : 8'h00;
    if (fl) q.delete();
    else begin
      popped = r && q.size() > 0;
      if (popped) void'(q.pop_front());
      if (p) begin
        if (q.size() < cap) q.push_back(pd);
        else ov_m = 1;
      end
    end
    wr_en = 0; rd_en = 0; fcr_we = 0;
    compare_all();
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 2 + 1);
    tag = "R1";
    compare_all();
    rst_n = 1'b1;
    #(PERIOD);
    compare_all();

    tag = "R2";
    step(1, 8'hA1, 0, 0, 0);
    step(1, 8'hB2, 0, 0, 0);
    tag = "R11";
    step(0, 0, 0, 0, 0);
    tag = "R2";
    step(0, 0, 1, 0, 0);

    tag = "R4";
    step(0, 0, 0, 1, 8'h01);
    tag = "R3";
    for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h10 + i), 0, 0, 0);
    step(1, 8'hEE, 0, 0, 0);
    tag = "R8";
    step(1, 8'h77, 1, 0, 0);
    tag = "R3";
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 8'(8'h40 + i), 0, 0, 0);

    tag = "R5";
    step(0, 0, 0, 1, 8'hFE);
    tag = "R2";
    step(1, 8'h55, 1, 0, 0);
    step(1, 8'h66, 1, 0, 0);
    step(1, 8'h67, 0, 0, 0);

    tag = "R6";
    step(0, 0, 0, 1, 8'hFF);
    for (int i = 0; i < 5; i++) step(1, 8'(8'h80 + i), 0, 0, 0);
    step(0, 0, 0, 1, 8'h49);
    step(0, 0, 0, 1, 8'hC3);

    tag = "R7";
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    tag = "R8";
    step(1, 8'h9A, 1, 0, 0);
    step(0, 0, 1, 0, 0);

    tag = "R9";
    for (int i = 0; i < DEPTH; i++) step(1, 8'(8'hC0 + i), 0, 0, 0);
    step(1, 8'hDD, 1, 1, 8'h03);
    step(1, 8'hDE, 0, 0, 0);
    step(1, 8'hDF, 1, 1, 8'h00);
    step(1, 8'hE0, 0, 0, 0);
    step(1, 8'hE1, 0, 0, 0);

    tag = "R10";
    for (int i = 0; i < 4000; i++) begin
      automatic int rv = int'($urandom_range(0, 99));
      automatic bit fw = (rv < 3);
      automatic logic [7:0] fd = 8'($urandom);
      step(($urandom_range(0, 99) < 55), 8'($urandom), ($urandom_range(0, 99) < 40), fw, fd);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule